// File: doc/BRIEF.md
# Two-Channel Prioritized Byte DMA Controller

This block moves bytes between locations on a simple synchronous memory bus for two independent channels. Each channel holds a source pointer, a destination pointer, a byte count and a control word, all written and read through a small register port. Every byte takes two bus cycles: a read at the source pointer, then a write of that byte at the destination pointer. After each byte both pointers step up by one and the count steps down by one.

Transfers are started by active-low hardware request pins. In single-byte mode each sampled request moves one byte and then frees the bus. In run-to-completion mode one request moves the whole count back to back. Channel 0 has fixed priority over channel 1. It can cut into a channel 1 run, but only between two read/write pairs, and channel 1 picks up again afterwards.

A CPU interrupt input pauses all outstanding work. The pair already on the bus completes. Each affected channel raises its pause flag. The flag clears, and the work resumes where it stopped, when the interrupt ends, or earlier if software writes the channel's enable bit to 1. A bus-owned output tells the CPU model which cycles to stall.

Top module: `dma2_ctrl`

## Requirements
- R1: A byte moves as one cycle with `bus_rd` high at the source pointer, followed directly by one cycle with `bus_wr` high at the destination pointer. In the write cycle, `bus_wdata` carries the byte returned on `bus_rdata` during the read cycle. `dma_active` is high in exactly these cycles.
- R2: After each write cycle, source and destination each increase by 1 and the count decreases by 1. When the count reaches 0, the enable bit clears and the channel's `done` bit is high for the single cycle that follows the final write cycle.
- R3: With mode bit 0 (single-byte), each accepted request moves exactly one byte and the channel then stays off the bus until another request is sampled.
- R4: With mode bit 1 (run), one accepted request moves every byte in the count, with no idle cycle between pairs (two cycles per byte).
- R5: A request is sampled on a clock edge while `dreq_n` is low and the channel is enabled. A low level while the channel is disabled is not recorded. The pending request clears when the channel is granted. The first read cycle comes no earlier than the second edge after the sample edge.
- R6: When both channels can start at a pair boundary, channel 0 is granted first.
- R7: A channel 0 request that arrives during a channel 1 run is granted only at the next pair boundary. Channel 1's run then continues with its next byte once channel 0 has nothing left to do.
- R8: A rising edge of `irq` sets the pause flag of every enabled channel that has a pending request or an unfinished run. A pair already started still completes. After that, a paused channel starts no new pair and its count stays frozen.
- R9: A falling edge of `irq` clears every pause flag, and paused work continues from the byte where it stopped.
- R10: Writing the control word of a paused channel with the enable bit set clears its pause flag and lets it resume at once, even while `irq` is still high.
- R11: The register address is {channel, field}, with field 0 = source, 1 = destination, 2 = count, 3 = control. The control word holds enable in bit 0, mode in bit 1 and the read-only pause flag in bit 2. Read data appears one cycle after the address is presented. All registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address {channel, field} |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| dreq_n | input | 2 | Active-low hardware transfer requests, one per channel |
| irq | input | 1 | High while the CPU is servicing an interrupt |
| bus_addr | output | 16 | Memory bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid during the read cycle |
| dma_active | output | 1 | High in every cycle the controller owns the bus |
| done | output | 2 | One-cycle pulse per channel when its count reaches zero |

## Verification
The bench goes after these cases:
- A channel 0 request that lands in the middle of a channel 1 run. A design that preempted mid-pair would issue a read while a write was still owed. A design that dropped the run afterwards would leave channel 1's count stuck above zero.
- Simultaneous requests. A design with the wrong priority would put channel 1's source pointer on the bus first.
- Interrupts arriving mid-run, both with a plain interrupt exit and with an enable rewrite while the interrupt is still active. A design that ignored the pause would keep `dma_active` high. A design that lost its place would write the wrong bytes to the wrong destinations.
- A request pulse on a disabled channel. A design that latched it would start a transfer as soon as the channel was enabled.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  typedef enum logic [1:0] {
    FLD_SRC = 2'd0,
    FLD_DST = 2'd1,
    FLD_CNT = 2'd2,
    FLD_CTL = 2'd3
  } dma_field_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MODE_BIT = 1;
  localparam int CTL_SUSP_BIT = 2;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_val,
  input  logic              req_n_in,
  input  logic              irq_rise,
  input  logic              irq_fall,
  input  logic              step,
  input  logic              grant,
  output logic              elig,
  output logic [ADDR_W-1:0] src_nx,
  output logic [ADDR_W-1:0] dst_nx,
  output logic              done
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic en_q, mode_q, susp_q, run_q, req_q;
  logic en_n, mode_n, susp_n, run_n, req_n, done_n, sample;

  assign sample = !req_n_in && en_q;

  always_comb begin
    src_nx = src_q;
    dst_nx = dst_q;
    cnt_n  = cnt_q;
    en_n   = en_q;
    mode_n = mode_q;
    susp_n = susp_q;
    run_n  = run_q;
    req_n  = req_q;
    done_n = 1'b0;
    if (step) begin
      src_nx = src_q + 1'b1;
      dst_nx = dst_q + 1'b1;
      cnt_n  = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        en_n   = 1'b0;
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
    if (irq_rise && en_n && (cnt_n != '0) && (req_q || run_n)) susp_n = 1'b1;
    if (irq_fall) susp_n = 1'b0;
    if (wr_en) begin
      case (dma_field_e'(wr_sel))
        FLD_SRC: src_nx = wr_data[ADDR_W-1:0];
        FLD_DST: dst_nx = wr_data[ADDR_W-1:0];
        FLD_CNT: cnt_n  = wr_data[CNT_W-1:0];
        default: begin
          en_n   = wr_data[CTL_EN_BIT];
          mode_n = wr_data[CTL_MODE_BIT];
          if (wr_data[CTL_EN_BIT]) susp_n = 1'b0;
          else begin
            run_n = 1'b0;
            req_n = 1'b0;
          end
        end
      endcase
    end
    elig = en_n && !susp_n && (cnt_n != '0) && (req_n || run_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      susp_q <= 1'b0;
      run_q  <= 1'b0;
      req_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      src_q  <= src_nx;
      dst_q  <= dst_nx;
      cnt_q  <= cnt_n;
      en_q   <= en_n;
      mode_q <= mode_n;
      susp_q <= susp_n;
      run_q  <= run_n || (grant && mode_n);
      req_q  <= (req_n && !grant) || sample;
      done   <= done_n;
    end
  end

  always_comb begin
    rd_val = '0;
    case (dma_field_e'(rd_sel))
      FLD_SRC: rd_val = REG_W'(src_q);
      FLD_DST: rd_val = REG_W'(dst_q);
      FLD_CNT: rd_val = REG_W'(cnt_q);
      default: begin
        rd_val[CTL_EN_BIT]   = en_q;
        rd_val[CTL_MODE_BIT] = mode_q;
        rd_val[CTL_SUSP_BIT] = susp_q;
      end
    endcase
  end

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    step && !wr_en |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_last_byte_R2: assert property (@(posedge clk) disable iff (rst)
    step && !wr_en && cnt_q == CNT_W'(1) |=> done && !en_q);
  assert_req_taken_R5: assert property (@(posedge clk) disable iff (rst)
    grant && req_n_in |=> !req_q);
  assert_pause_set_R8: assert property (@(posedge clk) disable iff (rst)
    irq_rise && en_q && run_q && cnt_q > CNT_W'(1) && !wr_en |=> susp_q);
  assert_pause_clear_R9: assert property (@(posedge clk) disable iff (rst)
    irq_fall |=> !susp_q);
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (req[c] && !taken) begin
        gnt[c] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  always_comb begin
    assert_grant_single_R6: assert ($onehot0(gnt));
  end
endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
  import dma2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16,
  localparam int CH_W  = $clog2(NCH),
  localparam int RA_W  = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NCH-1:0]    dreq_n,
  input  logic              irq,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              dma_active,
  output logic [NCH-1:0]    done
);
  logic              irq_q, irq_rise, irq_fall, any_gnt;
  logic [CH_W-1:0]   cur_q, gidx;
  logic [NCH-1:0]    elig, gnt, step;
  logic [ADDR_W-1:0] src_nx [NCH];
  logic [ADDR_W-1:0] dst_nx [NCH];
  logic [REG_W-1:0]  rd_all [NCH];

  assign irq_rise = irq && !irq_q;
  assign irq_fall = !irq && irq_q;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign step[c] = bus_wr && (cur_q == CH_W'(c));
      dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_chan (
        .clk(clk), .rst(rst),
        .wr_en(reg_we && (reg_addr[RA_W-1:2] == CH_W'(c))),
        .wr_sel(reg_addr[1:0]), .wr_data(reg_wdata),
        .rd_sel(reg_addr[1:0]), .rd_val(rd_all[c]),
        .req_n_in(dreq_n[c]), .irq_rise(irq_rise), .irq_fall(irq_fall),
        .step(step[c]), .grant(gnt[c]), .elig(elig[c]),
        .src_nx(src_nx[c]), .dst_nx(dst_nx[c]), .done(done[c])
      );
    end
  endgenerate

  dma2_arb #(.NCH(NCH)) u_arb (
    .req(elig & {NCH{!bus_rd}}),
    .gnt(gnt)
  );

  always_comb begin
    gidx = '0;
    for (int c = NCH - 1; c >= 0; c--) if (gnt[c]) gidx = CH_W'(c);
  end
  assign any_gnt = |gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= 1'b0;
      cur_q      <= '0;
      bus_addr   <= '0;
      bus_rd     <= 1'b0;
      bus_wr     <= 1'b0;
      bus_wdata  <= '0;
      dma_active <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      irq_q     <= irq;
      reg_rdata <= rd_all[reg_addr[RA_W-1:2]];
      if (bus_rd) begin
        bus_rd     <= 1'b0;
        bus_wr     <= 1'b1;
        bus_addr   <= dst_nx[cur_q];
        bus_wdata  <= bus_rdata;
        dma_active <= 1'b1;
      end else if (any_gnt) begin
        bus_rd     <= 1'b1;
        bus_wr     <= 1'b0;
        bus_addr   <= src_nx[gidx];
        cur_q      <= gidx;
        dma_active <= 1'b1;
      end else begin
        bus_rd     <= 1'b0;
        bus_wr     <= 1'b0;
        dma_active <= 1'b0;
      end
    end
  end

  assert_read_then_write_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_wr);
  assert_write_carries_read_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_wdata == $past(bus_rdata));
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  assert_pair_atomic_R7: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> $stable(cur_q));

  generate
    for (genvar c = 1; c < NCH; c++) begin : g_prio
      assert_low_index_first_R6: assert property (@(posedge clk) disable iff (rst)
        gnt[c] |-> !elig[0]);
    end
  endgenerate
endmodule

// File: tb/dma2_ctrl_bench.sv
module dma2_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  dreq_n = 2'b11;
  logic        irq = 1'b0;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, dma_active;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [1:0]  done;
  logic [7:0]  mem [256];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit ended = 0;

  int ms[2], md[2], mc[2], men[2], mmode[2], msusp[2], mrun[2], mreq[2], mdone[2];
  int mph, mcur, maddr, mwd, mrdata, mirq;

  always #4 clk = ~clk;

  dma2_ctrl u_dma2_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq_n(dreq_n), .irq(irq),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_active(dma_active), .done(done)
  );

  assign bus_rdata = mem[bus_addr[7:0]];

  function automatic int pat(int a);
    return (a * 7 + 3) & 255;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int mreg(int ch, int sel);
    case (sel)
      0: return ms[ch];
      1: return md[ch];
      2: return mc[ch];
      default: return msusp[ch] * 4 + mmode[ch] * 2 + men[ch];
    endcase
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin : mdl
    int ts[2], td[2], tc[2], ten[2], tmd[2], tsu[2], trn[2], trq[2];
    int tel[2], tsm[2], tdn[2], gr[2];
    int rise, fall, g;
    cyc++;
    if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        ms[c] = 0; md[c] = 0; mc[c] = 0; men[c] = 0; mmode[c] = 0;
        msusp[c] = 0; mrun[c] = 0; mreq[c] = 0; mdone[c] = 0;
      end
      mph = 0; mcur = 0; maddr = 0; mwd = 0; mrdata = 0; mirq = 0;
    end else begin
      rise = (irq && !mirq) ? 1 : 0;
      fall = (!irq && mirq) ? 1 : 0;
      mrdata = mreg(reg_addr[2], reg_addr[1:0]);
      for (int c = 0; c < 2; c++) begin
        ts[c] = ms[c]; td[c] = md[c]; tc[c] = mc[c]; ten[c] = men[c];
        tmd[c] = mmode[c]; tsu[c] = msusp[c]; trn[c] = mrun[c]; trq[c] = mreq[c];
        tdn[c] = 0; gr[c] = 0;
        tsm[c] = (dreq_n[c] == 1'b0 && men[c] != 0) ? 1 : 0;
        if (mph == 2 && mcur == c) begin
          ts[c] = (ts[c] + 1) & 16'hFFFF;
          td[c] = (td[c] + 1) & 16'hFFFF;
          tc[c] = (tc[c] - 1) & 255;
          if (tc[c] == 0) begin ten[c] = 0; trn[c] = 0; tdn[c] = 1; end
        end
        if (rise && ten[c] && tc[c] != 0 && (trq[c] || trn[c])) tsu[c] = 1;
        if (fall) tsu[c] = 0;
        if (reg_we && reg_addr[2] == c) begin
          case (reg_addr[1:0])
            0: ts[c] = reg_wdata;
            1: td[c] = reg_wdata;
            2: tc[c] = reg_wdata & 255;
            default: begin
              ten[c] = reg_wdata[0];
              tmd[c] = reg_wdata[1];
              if (reg_wdata[0]) tsu[c] = 0;
              else begin trn[c] = 0; trq[c] = 0; end
            end
          endcase
        end
        tel[c] = (ten[c] && !tsu[c] && tc[c] != 0 && (trq[c] || trn[c])) ? 1 : 0;
      end
      if (mph == 1) begin
        mph = 2;
        mwd = mem[maddr & 255];
        maddr = td[mcur];
      end else begin
        g = tel[0] ? 0 : (tel[1] ? 1 : -1);
        if (g >= 0) begin
          mph = 1; mcur = g; maddr = ts[g]; gr[g] = 1;
        end else mph = 0;
      end
      for (int c = 0; c < 2; c++) begin
        ms[c] = ts[c]; md[c] = td[c]; mc[c] = tc[c]; men[c] = ten[c];
        mmode[c] = tmd[c]; msusp[c] = tsu[c]; mdone[c] = tdn[c];
        mreq[c] = ((trq[c] && !gr[c]) || tsm[c]) ? 1 : 0;
        mrun[c] = (trn[c] || (gr[c] && tmd[c])) ? 1 : 0;
      end
      mirq = irq;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !ended) begin
      chk("R1 R3 R4 R6 R7 R8 bus_rd", bus_rd, mph == 1);
      chk("R1 bus_wr", bus_wr, mph == 2);
      chk("R1 R8 R9 R10 dma_active", dma_active, mph != 0);
      if (mph != 0) chk("R1 R5 R6 R7 R9 R10 bus_addr", bus_addr, maddr);
      if (mph == 2) chk("R1 bus_wdata", bus_wdata, mwd);
      chk("R2 done", done, mdone[1] * 2 + mdone[0]);
      chk("R11 reg_rdata", reg_rdata, mrdata);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int sel, input int val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(ch * 4 + sel); reg_wdata = 16'(val);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output int v);
    @(negedge clk);
    reg_addr = 3'(ch * 4 + sel);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    dreq_n[ch] = 1'b0;
    @(negedge clk);
    dreq_n[ch] = 1'b1;
  endtask

  task automatic setup(input int ch, input int s, input int d, input int n, input int ctl);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, n); wr(ch, 3, ctl);
  endtask

  task automatic chk_mem(input string what, input int s, input int d, input int n);
    for (int i = 0; i < n; i++) chk(what, mem[(d + i) & 255], pat(s + i));
  endtask

  task automatic finish_run();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !ended) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int v, held;
    for (int i = 0; i < 256; i++) mem[i] = 8'(pat(i));
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    chk("R1 reset bus_rd", bus_rd, 0);
    chk("R2 reset done", done, 0);
    rd(0, 3, v); chk("R11 reset ctrl ch0", v, 0);
    rd(1, 2, v); chk("R11 reset count ch1", v, 0);

    // single-byte mode on channel 0
    setup(0, 16'h10, 16'h80, 3, 1);
    wait_n(4);
    rd(0, 2, v); chk("R5 no request no progress", v, 3);
    pulse(0); wait_n(6);
    rd(0, 2, v); chk("R3 one byte per request", v, 2);
    rd(0, 0, v); chk("R2 source advanced", v, 16'h11);
    pulse(0); wait_n(6);
    pulse(0); wait_n(6);
    rd(0, 3, v); chk("R2 enable cleared at zero", v, 0);
    chk_mem("R1 single-byte data", 16'h10, 16'h80, 3);

    // request on a disabled channel is not recorded
    pulse(1);
    setup(1, 16'h20, 16'h90, 6, 3);
    wait_n(8);
    rd(1, 2, v); chk("R5 disabled request dropped", v, 6);

    // channel 0 cuts into a channel 1 run
    setup(0, 16'h30, 16'hA0, 1, 1);
    pulse(1); wait_n(5);
    pulse(0); wait_n(30);
    rd(1, 2, v); chk("R4 R7 run finished", v, 0);
    rd(0, 2, v); chk("R7 preempting byte done", v, 0);
    chk_mem("R4 R7 run data", 16'h20, 16'h90, 6);
    chk_mem("R7 preempt data", 16'h30, 16'hA0, 1);

    // simultaneous requests
    setup(0, 16'h00, 16'hB0, 2, 3);
    setup(1, 16'h08, 16'hB8, 2, 3);
    @(negedge clk); dreq_n = 2'b00;
    @(negedge clk); dreq_n = 2'b11;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (bus_rd) break;
    end
    chk("R6 channel 0 served first", bus_addr, 16'h00);
    wait_n(20);
    chk_mem("R6 ch0 data", 16'h00, 16'hB0, 2);
    chk_mem("R6 ch1 data", 16'h08, 16'hB8, 2);

    // interrupt pause with plain exit
    setup(1, 16'h10, 16'hC0, 8, 3);
    pulse(1); wait_n(5);
    irq = 1'b1;
    wait_n(4);
    chk("R8 bus released", dma_active, 0);
    rd(1, 3, v); chk("R8 pause flag set", v, 7);
    rd(1, 2, held);
    wait_n(5);
    rd(1, 2, v); chk("R8 count frozen", v, held);
    irq = 1'b0;
    wait_n(30);
    rd(1, 3, v); chk("R9 flag cleared and run ended", v, 2);
    chk_mem("R9 resumed data", 16'h10, 16'hC0, 8);

    // interrupt pause with software resume
    setup(0, 16'h20, 16'hD0, 6, 3);
    pulse(0); wait_n(3);
    irq = 1'b1;
    wait_n(4);
    chk("R8 channel 0 paused", dma_active, 0);
    wr(0, 3, 3);
    chk("R10 resumed at once", dma_active, 1);
    wait_n(20);
    rd(0, 3, v); chk("R10 flag cleared and run ended", v, 2);
    chk_mem("R10 resumed data", 16'h20, 16'hD0, 6);
    irq = 1'b0;
    wait_n(5);
    finish_run();
  end
endmodule